// File: doc/BRIEF.md
# Paired-Page Translation Lookup Unit

This block translates virtual addresses into physical addresses through a small, fully associative table held in flip-flops. Each table slot describes a pair of neighbouring pages, one even and one odd. The slot stores a virtual tag, a page-size mask, an address-space tag, a global flag, and a frame number, a valid bit and a dirty bit for each half of the pair. A current address-space tag is kept in a register of its own. Software loads that register and the table slots through two write ports.

A lookup presents a virtual address and a read/write flag with a request strobe. One cycle later the unit returns a 2-bit result code, the physical address, and readable and writable flags. A failed lookup reports why it failed: no slot covered the address, the selected half was not valid, or a write hit a half whose dirty bit is clear. Refill, caching and flushing belong to the surrounding logic.

The control is a two-state machine. ST_IDLE means no response is pending. ST_RESP means a response is being presented. The transitions are as follows. When `req_valid` is high, the machine moves from ST_IDLE to ST_RESP, or stays in ST_RESP. When `req_valid` is low, it moves from ST_RESP to ST_IDLE, or stays in ST_IDLE.

Top module: `tlb_lookup_unit`

## Requirements
- R1: During and after reset, `rsp_valid` is 0, every slot field is 0, and the current address-space tag is 0. As a result, a lookup right after reset of an address below 0x2000 hits slot 0 and reports code 10.
- R2: `rsp_valid` is 1 in the cycle after every cycle in which `req_valid` is sampled high, and 0 otherwise. The response fields are captured from the request sampled on that edge.
- R3: A slot is a candidate only when its global flag is 1 or its stored tag equals the current address-space tag. A write on `asid_we` changes the tag used by requests sampled on later edges only.
- R4: The effective mask of a slot is its stored mask ORed with 0x1FFF, so the smallest pair spans 8 KB. A slot covers an address when the address, with the effective-mask bits cleared, equals the stored virtual tag.
- R5: The half is selected by the address bit at the top set position of the effective mask, that is `mask & ~(mask>>1)`. A 0 there selects the even half (frame 0, valid 0, dirty 0), and a 1 selects the odd half.
- R6: If the selected half's valid bit is 0, the code is 10 (invalid), for reads and for writes alike.
- R7: A read, or a write to a half whose dirty bit is 1, gives code 00 (match). The physical address is then the selected frame ORed with the address bits under `mask>>1`.
- R8: A write to a valid half whose dirty bit is 0 gives code 11 (dirty violation).
- R9: On code 00, readable is 1 and writable equals the selected dirty bit. On any other code, readable, writable and the physical address are all 0.
- R10: When no slot covers the address, the code is 01 (no match).
- R11: When several slots cover the address, the slot with the lowest index decides the result.
- R12: A slot write on `ent_we` is seen by requests sampled on later edges. A request sampled on the same edge still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asid_we | input | 1 | Load the current address-space tag |
| asid_wdata | input | 8 | New current address-space tag (low byte of the context word) |
| ent_we | input | 1 | Slot write strobe |
| ent_idx | input | 3 | Slot index to write |
| ent_vtag | input | 32 | Virtual tag of the pair |
| ent_mask | input | 32 | Page-size mask (ORed with 0x1FFF internally) |
| ent_asid | input | 8 | Slot address-space tag |
| ent_global | input | 1 | Slot ignores the address-space tag |
| ent_frame_even | input | 32 | Physical frame of the even half |
| ent_frame_odd | input | 32 | Physical frame of the odd half |
| ent_valid_even | input | 1 | Even half valid |
| ent_dirty_even | input | 1 | Even half writable |
| ent_valid_odd | input | 1 | Odd half valid |
| ent_dirty_odd | input | 1 | Odd half writable |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load access |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 match, 01 no match, 10 invalid, 11 dirty violation |
| rsp_paddr | output | 32 | Physical address (0 unless code 00) |
| rsp_readable | output | 1 | Read permitted |
| rsp_writable | output | 1 | Write permitted |

## Verification
The hardest case to reach from the ports is an address covered by two slots at once. With a large mask, the covering slots can disagree on the selected half or on its valid and dirty bits. The stimulus loads two slots with the same virtual tag but different frames and bits, and loads a wide-mask slot whose pair overlaps a small one. It then probes each half with reads and writes. A phase of random lookups and slot rewrites over a few shared tags follows, which makes overlapping slots and same-edge write/lookup collisions occur many times. A behavioural model in the bench predicts every response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int VA_W   = 32;
    parameter int ASID_W = 8;
    parameter logic [VA_W-1:0] MIN_MASK = 32'h0000_1FFF;

    typedef enum logic [1:0] {
        RC_MATCH   = 2'b00,
        RC_NOMATCH = 2'b01,
        RC_INVALID = 2'b10,
        RC_DIRTY   = 2'b11
    } rsp_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_state_e;

    typedef struct packed {
        logic [VA_W-1:0]   vtag;
        logic [VA_W-1:0]   mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [VA_W-1:0]   frame_even;
        logic [VA_W-1:0]   frame_odd;
        logic              valid_even;
        logic              dirty_even;
        logic              valid_odd;
        logic              dirty_odd;
    } slot_t;

endpackage

// File: rtl/tlb_slot_store.sv
module tlb_slot_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  slot_t            wdata,
    output slot_t            slots [NUM_ENT]
);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        slot_t slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                slot_q <= wdata;
            end
        end
        assign slots[g] = slot_q;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(widx) < NUM_ENT)) |=> (slots[$past(widx)] == $past(wdata))); // R12

endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
    import tlb_pkg::*;
(
    input  slot_t             slot,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              hit,
    output logic              odd_sel,
    output logic [VA_W-1:0]   eff_mask
);

    logic tag_ok;
    logic space_ok;

    always_comb begin
        eff_mask = slot.mask | MIN_MASK;
        space_ok = slot.glob || (slot.asid == cur_asid);
        tag_ok   = ((vaddr & ~eff_mask) == slot.vtag);
        hit      = space_ok && tag_ok;
        odd_sel  = |(vaddr & eff_mask & ~(eff_mask >> 1));
    end

endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
    parameter int NUM_ENT = 8,
    parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] hits,
    output logic [NUM_ENT-1:0] grant,
    output logic [IDX_W-1:0]   win_idx,
    output logic               any_hit
);

    always_comb begin
        win_idx = '0;
        any_hit = 1'b0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (hits[i]) begin
                win_idx = IDX_W'(i);
                any_hit = 1'b1;
            end
        end
        grant = '0;
        if (any_hit) grant[win_idx] = 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R11
    AST_GRANT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |-> ((grant & hits) != '0)); // R11
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((grant - 1'b1) & hits) == '0)); // R11

endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              asid_we,
    input  logic [ASID_W-1:0] asid_wdata,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [VA_W-1:0]   ent_vtag,
    input  logic [VA_W-1:0]   ent_mask,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic              ent_global,
    input  logic [VA_W-1:0]   ent_frame_even,
    input  logic [VA_W-1:0]   ent_frame_odd,
    input  logic              ent_valid_even,
    input  logic              ent_dirty_even,
    input  logic              ent_valid_odd,
    input  logic              ent_dirty_odd,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_readable,
    output logic              rsp_writable
);

    fsm_state_e state_q, state_d;
    logic [ASID_W-1:0] cur_asid_q;

    slot_t             wr_slot;
    slot_t             slots     [NUM_ENT];
    logic [NUM_ENT-1:0] hit_v;
    logic [NUM_ENT-1:0] odd_v;
    logic [VA_W-1:0]   mask_v    [NUM_ENT];
    logic [NUM_ENT-1:0] grant;
    logic [IDX_W-1:0]  win_idx;
    logic              any_hit;

    slot_t             sel_slot;
    logic              sel_odd;
    logic [VA_W-1:0]   sel_mask;
    logic              sel_valid;
    logic              sel_dirty;
    logic [VA_W-1:0]   sel_frame;
    rsp_code_e         code_d;
    logic [VA_W-1:0]   paddr_d;
    logic              rd_d;
    logic              wr_d;

    always_comb begin
        wr_slot.vtag       = ent_vtag;
        wr_slot.mask       = ent_mask;
        wr_slot.asid       = ent_asid;
        wr_slot.glob       = ent_global;
        wr_slot.frame_even = ent_frame_even;
        wr_slot.frame_odd  = ent_frame_odd;
        wr_slot.valid_even = ent_valid_even;
        wr_slot.dirty_even = ent_dirty_even;
        wr_slot.valid_odd  = ent_valid_odd;
        wr_slot.dirty_odd  = ent_dirty_odd;
    end

    tlb_slot_store #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ent_we),
        .widx  (ent_idx),
        .wdata (wr_slot),
        .slots (slots)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cell
        tlb_match_cell u_cell (
            .slot     (slots[g]),
            .vaddr    (req_vaddr),
            .cur_asid (cur_asid_q),
            .hit      (hit_v[g]),
            .odd_sel  (odd_v[g]),
            .eff_mask (mask_v[g])
        );
    end

    tlb_prio_pick #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .hits    (hit_v),
        .grant   (grant),
        .win_idx (win_idx),
        .any_hit (any_hit)
    );

    // Current address-space tag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_asid_q <= '0;
        end else if (asid_we) begin
            cur_asid_q <= asid_wdata;
        end
    end

    // Result decode for the winning slot
    always_comb begin
        sel_slot  = slots[win_idx];
        sel_odd   = odd_v[win_idx];
        sel_mask  = mask_v[win_idx];
        sel_valid = sel_odd ? sel_slot.valid_odd : sel_slot.valid_even;
        sel_dirty = sel_odd ? sel_slot.dirty_odd : sel_slot.dirty_even;
        sel_frame = sel_odd ? sel_slot.frame_odd : sel_slot.frame_even;
        code_d    = RC_MATCH;
        paddr_d   = '0;
        rd_d      = 1'b0;
        wr_d      = 1'b0;
        if (!any_hit) begin
            code_d = RC_NOMATCH;
        end else if (!sel_valid) begin
            code_d = RC_INVALID;
        end else if (req_write && !sel_dirty) begin
            code_d = RC_DIRTY;
        end else begin
            code_d  = RC_MATCH;
            paddr_d = sel_frame | (req_vaddr & (sel_mask >> 1));
            rd_d    = 1'b1;
            wr_d    = sel_dirty;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_code     <= RC_MATCH;
            rsp_paddr    <= '0;
            rsp_readable <= 1'b0;
            rsp_writable <= 1'b0;
        end else if (req_valid) begin
            rsp_code     <= code_d;
            rsp_paddr    <= paddr_d;
            rsp_readable <= rd_d;
            rsp_writable <= wr_d;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_WRITABLE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_writable) |-> (rsp_code == RC_MATCH)); // R9
    AST_READABLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == RC_MATCH)) |-> rsp_readable); // R9
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code != RC_MATCH)) |-> (rsp_paddr == '0)); // R9
    AST_ASID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !asid_we |=> $stable(cur_asid_q)); // R3

endmodule

// File: tb/tb_tlb_lookup_unit.sv
module tb_tlb_lookup_unit;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        asid_we = 1'b0;
    logic [7:0]  asid_wdata = '0;
    logic        ent_we = 1'b0;
    logic [2:0]  ent_idx = '0;
    logic [31:0] ent_vtag = '0, ent_mask = '0;
    logic [7:0]  ent_asid = '0;
    logic        ent_global = 1'b0;
    logic [31:0] ent_frame_even = '0, ent_frame_odd = '0;
    logic        ent_valid_even = 1'b0, ent_dirty_even = 1'b0;
    logic        ent_valid_odd = 1'b0, ent_dirty_odd = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_paddr;
    logic        rsp_readable, rsp_writable;

    always #2 clk = ~clk;

    tlb_lookup_unit dut (
        .clk(clk), .rst_n(rst_n),
        .asid_we(asid_we), .asid_wdata(asid_wdata),
        .ent_we(ent_we), .ent_idx(ent_idx), .ent_vtag(ent_vtag), .ent_mask(ent_mask),
        .ent_asid(ent_asid), .ent_global(ent_global),
        .ent_frame_even(ent_frame_even), .ent_frame_odd(ent_frame_odd),
        .ent_valid_even(ent_valid_even), .ent_dirty_even(ent_dirty_even),
        .ent_valid_odd(ent_valid_odd), .ent_dirty_odd(ent_dirty_odd),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
        .rsp_readable(rsp_readable), .rsp_writable(rsp_writable)
    );

    // Behavioural reference model
    logic [31:0] m_vtag [N], m_mask [N], m_fe [N], m_fo [N];
    logic [7:0]  m_asid [N];
    bit          m_g [N], m_ve [N], m_de [N], m_vo [N], m_do [N];
    logic [7:0]  m_cur;
    bit          e_valid;
    logic [1:0]  e_code;
    logic [31:0] e_pa;
    bit          e_rd, e_wr;

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";
    bit done = 0;

    function automatic void ref_lookup(input logic [31:0] va, input bit wr,
                                       output logic [1:0] c, output logic [31:0] pa,
                                       output bit rd, output bit wf);
        bit found = 0;
        c = 2'b01; pa = '0; rd = 0; wf = 0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] m;
            m = m_mask[i] | 32'h1FFF;
            if (!found && (m_g[i] || m_asid[i] == m_cur) && ((va & ~m) == m_vtag[i])) begin
                bit odd, v, d;
                logic [31:0] fr;
                found = 1;
                odd = (va & m & ~(m >> 1)) != 0;
                v  = odd ? m_vo[i] : m_ve[i];
                d  = odd ? m_do[i] : m_de[i];
                fr = odd ? m_fo[i] : m_fe[i];
                if (!v) c = 2'b10;
                else if (wr && !d) c = 2'b11;
                else begin
                    c = 2'b00; pa = fr | (va & (m >> 1)); rd = 1; wf = d;
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_vtag[i] = '0; m_mask[i] = '0; m_fe[i] = '0; m_fo[i] = '0; m_asid[i] = '0;
                m_g[i] = 0; m_ve[i] = 0; m_de[i] = 0; m_vo[i] = 0; m_do[i] = 0;
            end
            m_cur = '0;
            e_valid = 0;
        end else begin
            e_valid = req_valid;
            if (req_valid) ref_lookup(req_vaddr, req_write, e_code, e_pa, e_rd, e_wr);
            if (ent_we) begin
                m_vtag[ent_idx] = ent_vtag; m_mask[ent_idx] = ent_mask;
                m_asid[ent_idx] = ent_asid; m_g[ent_idx] = ent_global;
                m_fe[ent_idx] = ent_frame_even; m_fo[ent_idx] = ent_frame_odd;
                m_ve[ent_idx] = ent_valid_even; m_de[ent_idx] = ent_dirty_even;
                m_vo[ent_idx] = ent_valid_odd; m_do[ent_idx] = ent_dirty_odd;
            end
            if (asid_we) m_cur = asid_wdata;
        end
    end

    function automatic string code_tag(input logic [1:0] c);
        case (c)
            2'b00: return "R7";
            2'b01: return "R10";
            2'b10: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (!rst_n) begin
                if (rsp_valid !== 1'b0) begin
                    bad++;
                    $display("FAIL R1 rsp_valid in reset: got %0b exp 0", rsp_valid);
                end
            end else if (rsp_valid !== e_valid) begin
                bad++;
                $display("FAIL R2 (%s) rsp_valid: got %0b exp %0b", cur_tag, rsp_valid, e_valid);
            end else if (e_valid) begin
                total++;
                if (rsp_code !== e_code || rsp_paddr !== e_pa ||
                    rsp_readable !== e_rd || rsp_writable !== e_wr) begin
                    bad++;
                    $display("FAIL %s/%s/R9 got code=%b pa=%h rd=%0b wr=%0b exp code=%b pa=%h rd=%0b wr=%0b",
                             cur_tag, code_tag(e_code), rsp_code, rsp_paddr, rsp_readable,
                             rsp_writable, e_code, e_pa, e_rd, e_wr);
                end
            end
        end
    end

    task automatic put_slot(input int idx, input logic [31:0] vt, input logic [31:0] mk,
                            input logic [7:0] as, input bit g,
                            input logic [31:0] fe, input logic [31:0] fo,
                            input bit ve, input bit de, input bit vo, input bit dd);
        ent_we = 1; ent_idx = 3'(idx); ent_vtag = vt; ent_mask = mk; ent_asid = as;
        ent_global = g; ent_frame_even = fe; ent_frame_odd = fo;
        ent_valid_even = ve; ent_dirty_even = de; ent_valid_odd = vo; ent_dirty_odd = dd;
        @(negedge clk);
        ent_we = 0;
    endtask

    task automatic look(input logic [31:0] va, input bit wr);
        req_valid = 1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic set_asid(input logic [7:0] a);
        asid_we = 1; asid_wdata = a;
        @(negedge clk);
        asid_we = 0;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired: got hang exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: cleared slots match low addresses with tag 0 and report invalid
        cur_tag = "R1";
        look(32'h0000_0100, 0);
        @(negedge clk);

        // R7, R8, R9: basic 8 KB pair
        set_asid(8'h05);
        cur_tag = "R12";
        put_slot(0, 32'h0040_0000, 32'h0, 8'h05, 0, 32'h1000_0000, 32'h2000_0000, 1, 1, 1, 0);
        cur_tag = "R7";
        look(32'h0040_0123, 0);
        look(32'h0040_0123, 1);
        cur_tag = "R8";
        look(32'h0040_1456, 1);
        cur_tag = "R5";
        look(32'h0040_1456, 0);
        // R3: tag mismatch then global slot
        cur_tag = "R3";
        set_asid(8'h06);
        look(32'h0040_0123, 0);
        put_slot(1, 32'h0060_0000, 32'h0, 8'h99, 1, 32'h3000_0000, 32'h3100_0000, 1, 0, 0, 0);
        look(32'h0060_0ABC, 0);
        look(32'h0060_0ABC, 1);
        // R6: invalid half for reads and writes
        cur_tag = "R6";
        look(32'h0060_1000, 0);
        look(32'h0060_1000, 1);
        // R4, R5: wide mask pair, select bit 0x4000
        cur_tag = "R4";
        put_slot(2, 32'h0080_0000, 32'h0000_6000, 8'h06, 0, 32'h4000_0000, 32'h5000_0000, 0, 0, 1, 1);
        look(32'h0080_5ABC, 1);
        look(32'h0080_3ABC, 0);
        look(32'h0080_8000, 0);
        // R11: two slots cover the same pair
        cur_tag = "R11";
        put_slot(4, 32'h00A0_0000, 32'h0, 8'h06, 0, 32'h6000_0000, 32'h6100_0000, 1, 0, 1, 1);
        put_slot(3, 32'h00A0_0000, 32'h0, 8'h06, 0, 32'h7000_0000, 32'h7100_0000, 1, 1, 0, 0);
        look(32'h00A0_0010, 1);
        look(32'h00A0_1010, 0);
        // R12: write and lookup on the same edge see old contents
        cur_tag = "R12";
        ent_we = 1; ent_idx = 3; ent_vtag = 32'h00A0_0000; ent_mask = 0; ent_asid = 8'h77;
        ent_global = 0; ent_frame_even = 32'h7700_0000; ent_frame_odd = 0;
        ent_valid_even = 1; ent_dirty_even = 1; ent_valid_odd = 0; ent_dirty_odd = 0;
        req_valid = 1; req_vaddr = 32'h00A0_0020; req_write = 0;
        @(negedge clk);
        ent_we = 0; req_valid = 0;
        look(32'h00A0_0020, 0);
        // R2: back-to-back requests and gaps
        cur_tag = "R2";
        req_valid = 1;
        for (int k = 0; k < 4; k++) begin
            req_vaddr = 32'h0080_4000 + 32'(k * 32'h1000); req_write = k[0];
            @(negedge clk);
        end
        req_valid = 0;
        repeat (2) @(negedge clk);
        // Random phase over shared tags
        cur_tag = "RND";
        for (int k = 0; k < 600; k++) begin
            logic [31:0] base;
            base = 32'h0040_0000 + (32'($urandom_range(0, 3)) << 21);
            if ($urandom_range(0, 5) == 0) begin
                ent_we = 1; ent_idx = 3'($urandom_range(0, 7));
                ent_vtag = base; ent_mask = ($urandom_range(0, 1) == 1) ? 32'h0000_6000 : 32'h0;
                ent_asid = 8'($urandom_range(5, 6)); ent_global = ($urandom_range(0, 3) == 0);
                ent_frame_even = 32'($urandom) & 32'hFFFF_8000;
                ent_frame_odd  = 32'($urandom) & 32'hFFFF_8000;
                ent_valid_even = 1'($urandom); ent_dirty_even = 1'($urandom);
                ent_valid_odd  = 1'($urandom); ent_dirty_odd  = 1'($urandom);
            end else ent_we = 0;
            asid_we = ($urandom_range(0, 15) == 0);
            asid_wdata = 8'($urandom_range(5, 6));
            req_valid = ($urandom_range(0, 3) != 0);
            req_vaddr = base | (32'($urandom) & 32'h0000_7FFF);
            req_write = 1'($urandom);
            @(negedge clk);
        end
        ent_we = 0; asid_we = 0; req_valid = 0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule